// File: doc/BRIEF.md
# Page Entry Permission Fault Checker

This block judges a single leaf page-table entry against one memory access and the current paging controls, and states whether the access succeeds or produces a page fault. When the access faults, the block also forms the error code that goes with the fault. A page walker hands the block the final 64-bit entry it found, along with the access kind and the control state. The block returns a registered verdict one cycle later. It does not walk tables, hold a TLB or touch memory.

The access is described by four flags: user or supervisor, write, instruction fetch, and implicit (system-structure) access. The controls cover the following:
- write protection for supervisor writes;
- the alignment-check override for supervisor access to user pages;
- the no-execute enable;
- supervisor execute and access prevention on user pages;
- user and supervisor protection-key enables, each with access-disable and write-disable bits for key 15.

The walk context is the number of paging levels, the table level of the entry, the superpage order (0 for a small page), whether the entry is a leaf, the physical address width, whether 1 GB pages exist, and a vendor select.

The checks run in a fixed priority:
1. not present;
2. reserved bits;
3. fetch rights, or protection key for data;
4. user and supervisor data rights.

Only the first failing check decides the error code.

Top module: `pte_fault_check`

## Requirements
- R1: A request pulse on `req_valid` produces `out_valid` high for exactly one cycle, at the next clock edge. `out_fault`/`out_code` update at that edge and hold until the next request. After reset all outputs are 0.
- R2: On every fault, error code bit 1 equals the write flag of the access and bit 2 equals the user flag, whether or not the entry is present.
- R3: Error code bit 4 carries the fetch flag on a fault only when no-execute is usable or supervisor execute prevention is on. No-execute is usable when `levels` >= 3 and `ctl_nxe` is set.
- R4: An entry with bit 0 clear faults with code bit 0 clear. An entry with bit 0 set gives code bit 0 set on any fault.
- R5: Entry bits from `pa_width` up to bit 51 are reserved. So is bit 63 when no-execute is unusable. A set reserved bit faults with code bit 3 set.
- R6: These entry bits are also reserved:
  - bit 7 at table level 4;
  - bit 8 at table level 4 when `vendor_sel` is 1;
  - bit 7 at table level 3 when `gb_pages` is 0;
  - bits 62:52 when `levels` is 3.
- R7: For a nonzero `page_order`, entry bits 13 to `page_order`-1 are reserved. Bit 12 is not reserved.
- R8: A fetch faults in three cases:
  - entry bit 63 is set;
  - the fetch is a user fetch and entry bit 2 is clear;
  - the fetch is a supervisor fetch, entry bit 2 is set and `ctl_smep` is set.
- R9: The key check covers data accesses on a leaf entry with `levels` 4 and entry bits 62:59 all ones. The entry's bit 2 selects the key bank: user bank (`ctl_pke`, `ukey_ad`, `ukey_wd`) when set, supervisor bank (`ctl_pks`, `skey_ad`, `skey_wd`) when clear. Access-disable always faults. Write-disable faults only on a write that is a user access or made with `ctl_wp`. A key fault sets code bit 5.
- R10: A user data access faults when entry bit 2 is clear. A user write faults when entry bit 1 is clear.
- R11: A supervisor write faults on an entry with bit 1 clear only when `ctl_wp` is set. A supervisor data access to an entry with bit 2 set faults when `ctl_smap` is set and either the access is implicit or `ctl_ac` is clear.
- R12: On a fault, code bit 16 equals the implicit flag. An access that succeeds gives `out_fault` 0 and `out_code` 0.
- R13: Priority is not-present, then reserved, then fetch or key, then data rights. A reserved-bit fault never sets bit 5, and a not-present fault never sets bit 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe |
| pte | input | 64 | Leaf entry under check |
| acc_user | input | 1 | Access made from user mode |
| acc_write | input | 1 | Access is a write |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_implicit | input | 1 | Access is an implicit system access |
| ctl_wp | input | 1 | Supervisor write protection |
| ctl_ac | input | 1 | Access-prevention override flag |
| ctl_nxe | input | 1 | No-execute enable |
| ctl_smep | input | 1 | Supervisor execute prevention |
| ctl_smap | input | 1 | Supervisor access prevention |
| ctl_pke | input | 1 | User protection keys enable |
| ctl_pks | input | 1 | Supervisor protection keys enable |
| ukey_ad | input | 1 | User key 15 access-disable |
| ukey_wd | input | 1 | User key 15 write-disable |
| skey_ad | input | 1 | Supervisor key 15 access-disable |
| skey_wd | input | 1 | Supervisor key 15 write-disable |
| levels | input | 3 | Paging level count (2, 3 or 4) |
| tbl_level | input | 3 | Table level of the entry (1 to 4) |
| is_leaf | input | 1 | Entry is the final translation |
| page_order | input | 6 | Superpage order in address bits, 0 for small page |
| pa_width | input | 6 | Physical address width |
| vendor_sel | input | 1 | Makes bit 8 reserved at level 4 |
| gb_pages | input | 1 | 1 GB pages supported |
| out_valid | output | 1 | Result strobe |
| out_fault | output | 1 | Access faults |
| out_code | output | 17 | Error code, 0 on success |

## Verification
Two situations are hard to reach from random entries: a key-15 fault, and a reserved-bit hit that has to win over a key or rights fault. A key fault needs four-level paging, a leaf entry, all four key bits set and the matching bank enabled at once. The reserved-over-key case also needs a reserved bit set on top of that. The stimulus therefore builds these entries by hand, covering each bank, access-disable versus write-disable, and write-protect on and off. A random pass then draws entries with the key field forced often to ones and reserved bits planted at chosen positions. Each random draw is compared against the bench's own rule model.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
    localparam int ERR_W   = 17;
    // error code bit positions
    localparam int EB_P    = 0;
    localparam int EB_W    = 1;
    localparam int EB_U    = 2;
    localparam int EB_R    = 3;
    localparam int EB_I    = 4;
    localparam int EB_K    = 5;
    localparam int EB_IMP  = 16;
    // entry bit positions
    localparam int PB_P    = 0;
    localparam int PB_RW   = 1;
    localparam int PB_US   = 2;
    localparam int PB_PS   = 7;
    localparam int PB_G    = 8;
    localparam int PB_PAT  = 12;
    localparam int PB_NX   = 63;
    localparam int ADDR_TOP = 51;
    localparam int HI3_LO  = 52;
    localparam int HI3_HI  = 62;
    localparam int KEY_LO  = 59;
    localparam int KEY_W   = 4;

    typedef struct packed {
        logic             valid;
        logic             fault;
        logic [ERR_W-1:0] code;
    } result_t;
endpackage

// File: rtl/pfc_rsvd_mask.sv
module pfc_rsvd_mask
    import pfc_pkg::*;
#(
    parameter int PTE_W = 64,
    parameter int LVL_W = 3,
    parameter int ORD_W = 6,
    parameter int PAW_W = 6
) (
    input  logic [LVL_W-1:0] levels,
    input  logic [LVL_W-1:0] tbl_level,
    input  logic [ORD_W-1:0] page_order,
    input  logic [PAW_W-1:0] pa_width,
    input  logic             vendor_sel,
    input  logic             gb_pages,
    input  logic             nx_usable,
    output logic [PTE_W-1:0] mask
);
    logic lvl4_d, lvl3_d, three_lvl_d, super_d;

    always_comb begin
        lvl4_d      = (tbl_level == LVL_W'(4));
        lvl3_d      = (tbl_level == LVL_W'(3));
        three_lvl_d = (levels == LVL_W'(3));
        super_d     = (page_order != '0);
    end

    for (genvar g = 0; g < PTE_W; g++) begin : g_bit
        assign mask[g] =
              (g >= int'(pa_width) && g <= ADDR_TOP)
            | (super_d && g > PB_PAT && g < int'(page_order))
            | (three_lvl_d && g >= HI3_LO && g <= HI3_HI)
            | (g == PB_NX && !nx_usable)
            | (g == PB_PS && (lvl4_d || (lvl3_d && !gb_pages)))
            | (g == PB_G && lvl4_d && vendor_sel);
    end
endmodule

// File: rtl/pfc_key_check.sv
module pfc_key_check
    import pfc_pkg::*;
(
    input  logic [KEY_W-1:0] key,
    input  logic             us_bit,
    input  logic             fetch,
    input  logic             leaf,
    input  logic             four_lvl,
    input  logic             user,
    input  logic             write,
    input  logic             wp,
    input  logic             pke,
    input  logic             pks,
    input  logic             uad,
    input  logic             uwd,
    input  logic             sad,
    input  logic             swd,
    output logic             key_fault
);
    logic applies_d, en_d, ad_d, wd_d;

    always_comb begin
        applies_d = !fetch && leaf && four_lvl && (&key);
        en_d      = us_bit ? pke : pks;
        ad_d      = us_bit ? uad : sad;
        wd_d      = us_bit ? uwd : swd;
        key_fault = applies_d && en_d && (ad_d || (write && wd_d && (user || wp)));
    end
endmodule

// File: rtl/pfc_rights_check.sv
module pfc_rights_check (
    input  logic fetch,
    input  logic user,
    input  logic write,
    input  logic implicit_acc,
    input  logic nx_bit,
    input  logic us_bit,
    input  logic rw_bit,
    input  logic wp,
    input  logic ac,
    input  logic smep,
    input  logic smap,
    output logic rights_fault
);
    logic fetch_bad_d, user_bad_d, sup_bad_d;

    always_comb begin
        fetch_bad_d  = nx_bit || (user && !us_bit) || (!user && us_bit && smep);
        user_bad_d   = !us_bit || (write && !rw_bit);
        sup_bad_d    = (write && !rw_bit && wp) ||
                       (us_bit && smap && (implicit_acc || !ac));
        rights_fault = fetch ? fetch_bad_d : (user ? user_bad_d : sup_bad_d);
    end
endmodule

// File: rtl/pte_fault_check.sv
module pte_fault_check
    import pfc_pkg::*;
#(
    parameter int PTE_W = 64,
    parameter int LVL_W = 3,
    parameter int ORD_W = 6,
    parameter int PAW_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [PTE_W-1:0] pte,
    input  logic             acc_user,
    input  logic             acc_write,
    input  logic             acc_fetch,
    input  logic             acc_implicit,
    input  logic             ctl_wp,
    input  logic             ctl_ac,
    input  logic             ctl_nxe,
    input  logic             ctl_smep,
    input  logic             ctl_smap,
    input  logic             ctl_pke,
    input  logic             ctl_pks,
    input  logic             ukey_ad,
    input  logic             ukey_wd,
    input  logic             skey_ad,
    input  logic             skey_wd,
    input  logic [LVL_W-1:0] levels,
    input  logic [LVL_W-1:0] tbl_level,
    input  logic             is_leaf,
    input  logic [ORD_W-1:0] page_order,
    input  logic [PAW_W-1:0] pa_width,
    input  logic             vendor_sel,
    input  logic             gb_pages,
    output logic             out_valid,
    output logic             out_fault,
    output logic [ERR_W-1:0] out_code
);
    logic             nx_usable;
    logic [PTE_W-1:0] rsvd_mask;
    logic             key_fault, rights_fault;
    result_t          res_d, res_q;

    assign nx_usable = (levels >= LVL_W'(3)) && ctl_nxe;

    pfc_rsvd_mask #(.PTE_W(PTE_W), .LVL_W(LVL_W), .ORD_W(ORD_W), .PAW_W(PAW_W)) u_mask (
        .levels(levels), .tbl_level(tbl_level), .page_order(page_order),
        .pa_width(pa_width), .vendor_sel(vendor_sel), .gb_pages(gb_pages),
        .nx_usable(nx_usable), .mask(rsvd_mask)
    );

    pfc_key_check u_key (
        .key(pte[KEY_LO +: KEY_W]), .us_bit(pte[PB_US]), .fetch(acc_fetch),
        .leaf(is_leaf), .four_lvl(levels == LVL_W'(4)), .user(acc_user),
        .write(acc_write), .wp(ctl_wp), .pke(ctl_pke), .pks(ctl_pks),
        .uad(ukey_ad), .uwd(ukey_wd), .sad(skey_ad), .swd(skey_wd),
        .key_fault(key_fault)
    );

    pfc_rights_check u_rights (
        .fetch(acc_fetch), .user(acc_user), .write(acc_write),
        .implicit_acc(acc_implicit), .nx_bit(pte[PB_NX]), .us_bit(pte[PB_US]),
        .rw_bit(pte[PB_RW]), .wp(ctl_wp), .ac(ctl_ac), .smep(ctl_smep),
        .smap(ctl_smap), .rights_fault(rights_fault)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = 1'b0;
        if (req_valid) begin
            res_d.valid         = 1'b1;
            res_d.fault         = 1'b0;
            res_d.code          = '0;
            res_d.code[EB_W]    = acc_write;
            res_d.code[EB_U]    = acc_user;
            res_d.code[EB_I]    = acc_fetch && (nx_usable || ctl_smep);
            res_d.code[EB_IMP]  = acc_implicit;
            if (!pte[PB_P]) begin
                res_d.fault = 1'b1;
            end else begin
                res_d.code[EB_P] = 1'b1;
                if (|(pte & rsvd_mask)) begin
                    res_d.fault      = 1'b1;
                    res_d.code[EB_R] = 1'b1;
                end else if (key_fault) begin
                    res_d.fault      = 1'b1;
                    res_d.code[EB_K] = 1'b1;
                end else if (rights_fault) begin
                    res_d.fault      = 1'b1;
                end
            end
            if (!res_d.fault) res_d.code = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid = res_q.valid;
    assign out_fault = res_q.fault;
    assign out_code  = res_q.code;

    a_r1_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);
    a_r1_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid && $stable(out_code));
    a_r2_uw_copied: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!out_fault ||
            (out_code[EB_U] == $past(acc_user) && out_code[EB_W] == $past(acc_write))));
    a_r4_absent_no_p: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !pte[PB_P]) |=> out_fault && !out_code[EB_P] && !out_code[EB_R]);
    a_r4_present_sets_p: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pte[PB_P]) |=> (!out_fault || out_code[EB_P]));
    a_r12_success_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !out_fault |-> out_code == '0);
    a_r13_r_excludes_k: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $countones({out_code[EB_R], out_code[EB_K]}) <= 1);
endmodule

// File: tb/tb_pte_fault_check.sv
`timescale 1ns/100ps
module tb_pte_fault_check;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] pte;
    logic        acc_user, acc_write, acc_fetch, acc_implicit;
    logic        ctl_wp, ctl_ac, ctl_nxe, ctl_smep, ctl_smap, ctl_pke, ctl_pks;
    logic        ukey_ad, ukey_wd, skey_ad, skey_wd;
    logic [2:0]  levels, tbl_level;
    logic        is_leaf;
    logic [5:0]  page_order, pa_width;
    logic        vendor_sel, gb_pages;
    logic        out_valid, out_fault;
    logic [16:0] out_code;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    pte_fault_check dut (.*);

    localparam logic [63:0] BASE = 64'h0000_0000_4000_0000;
    localparam logic [63:0] KEY15 = 64'h7800_0000_0000_0000;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic defaults();
        pte = BASE | 64'h7;
        {acc_user, acc_write, acc_fetch, acc_implicit} = 4'b0;
        {ctl_wp, ctl_ac, ctl_nxe, ctl_smep, ctl_smap, ctl_pke, ctl_pks} = 7'b0;
        {ukey_ad, ukey_wd, skey_ad, skey_wd} = 4'b0;
        levels = 3'd4; tbl_level = 3'd1; is_leaf = 1'b1;
        page_order = 6'd0; pa_width = 6'd46; vendor_sel = 1'b0; gb_pages = 1'b1;
    endtask

    task automatic acc(input logic u, input logic w, input logic f, input logic i);
        acc_user = u; acc_write = w; acc_fetch = f; acc_implicit = i;
    endtask

    // behavioural rule model: returns {fault, code}
    function automatic logic [17:0] model();
        logic [63:0] m = '0;
        logic [16:0] c = '0;
        bit nxok = (levels >= 3) && ctl_nxe;
        bit en, ad, wd;
        for (int i = 0; i < 64; i++)
            if (i >= pa_width && i <= 51) m[i] = 1'b1;
        if (!nxok) m[63] = 1'b1;
        if (tbl_level == 4) begin
            m[7] = 1'b1;
            if (vendor_sel) m[8] = 1'b1;
        end else if (tbl_level == 3 && !gb_pages) m[7] = 1'b1;
        if (page_order != 0)
            for (int i = 13; i < page_order; i++) m[i] = 1'b1;
        if (levels == 3)
            for (int i = 52; i <= 62; i++) m[i] = 1'b1;
        c[1] = acc_write; c[2] = acc_user; c[16] = acc_implicit;
        if (acc_fetch && (nxok || ctl_smep)) c[4] = 1'b1;
        if (!pte[0]) return {1'b1, c};
        c[0] = 1'b1;
        if ((pte & m) != 0) begin c[3] = 1'b1; return {1'b1, c}; end
        if (acc_fetch) begin
            if (pte[63]) return {1'b1, c};
            if (acc_user && !pte[2]) return {1'b1, c};
            if (!acc_user && pte[2] && ctl_smep) return {1'b1, c};
            return 18'h0;
        end
        if (levels == 4 && is_leaf && pte[62:59] == 4'hF) begin
            en = pte[2] ? ctl_pke : ctl_pks;
            ad = pte[2] ? ukey_ad : skey_ad;
            wd = pte[2] ? ukey_wd : skey_wd;
            if (en && (ad || (acc_write && wd && (acc_user || ctl_wp)))) begin
                c[5] = 1'b1; return {1'b1, c};
            end
        end
        if (acc_user) begin
            if (!pte[2]) return {1'b1, c};
            if (acc_write && !pte[1]) return {1'b1, c};
        end else begin
            if (acc_write && !pte[1] && ctl_wp) return {1'b1, c};
            if (pte[2] && ctl_smap && (acc_implicit || !ctl_ac)) return {1'b1, c};
        end
        return 18'h0;
    endfunction

    // one request; checks valid pulse, result, then hold with valid low (R1)
    task automatic issue(input string tag, input logic ef, input logic [16:0] ec);
        @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R1 valid"}, 32'(out_valid), 32'd1);
        check({tag, " fault"}, 32'(out_fault), 32'(ef));
        check({tag, " code"}, 32'(out_code), 32'(ec));
        @(negedge clk);
        check({tag, " R1 pulse end"}, 32'(out_valid), 32'd0);
        check({tag, " R1 held"}, 32'(out_code), 32'(ec));
    endtask

    task automatic issue_model(input string tag);
        logic [17:0] e = model();
        issue(tag, e[17], e[16:0]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        defaults();
        repeat (3) @(negedge clk);
        check("R1 reset valid", 32'(out_valid), 0);
        check("R1 reset fault", 32'(out_fault), 0);
        check("R1 reset code", 32'(out_code), 0);
        rst_n = 1'b1;

        // R12 success
        acc(1,0,0,0); issue("R12 user read ok", 0, 17'h0);
        // R4 / R2 not present
        pte = BASE | 64'h6; acc(1,1,0,0); issue("R4 R2 absent user write", 1, 17'h6);
        acc(0,0,0,0); issue("R4 absent sup read", 1, 17'h0);
        acc(0,0,0,1); issue("R12 absent implicit", 1, 17'h10000);
        // R5 physical width and NX reserved
        defaults(); pte = BASE | 64'h7 | (64'h1 << 50); issue("R5 pa bit 50", 1, 17'h9);
        pte = BASE | 64'h7 | (64'h1 << 45); issue("R5 pa bit 45 ok", 0, 17'h0);
        pte = BASE | 64'h7 | (64'h1 << 63); issue("R5 nx unusable", 1, 17'h9);
        ctl_nxe = 1; issue("R5 nx usable", 0, 17'h0);
        levels = 3'd2; issue("R5 nx two level", 1, 17'h9);
        // R6 level dependent
        defaults(); tbl_level = 3'd4; pte = BASE | 64'h87; issue("R6 PS level4", 1, 17'h9);
        pte = BASE | 64'h107; issue("R6 G vendor0", 0, 17'h0);
        vendor_sel = 1; issue("R6 G vendor1", 1, 17'h9);
        defaults(); tbl_level = 3'd3; gb_pages = 0; pte = BASE | 64'h87;
        issue("R6 PS level3 no gb", 1, 17'h9);
        gb_pages = 1; page_order = 6'd30; issue("R6 gb superpage ok", 0, 17'h0);
        defaults(); levels = 3'd3; pte = BASE | 64'h7 | (64'h1 << 55);
        issue("R6 three level high bit", 1, 17'h9);
        levels = 3'd4; issue("R6 four level bit55 ok", 0, 17'h0);
        // R7 superpage order
        defaults(); tbl_level = 3'd2; page_order = 6'd21;
        pte = BASE | 64'h1087; issue("R7 PAT bit ok", 0, 17'h0);
        pte = BASE | 64'h2087; issue("R7 bit13", 1, 17'h9);
        pte = BASE | 64'h87 | (64'h1 << 20); issue("R7 bit20", 1, 17'h9);
        pte = BASE | 64'h87 | (64'h1 << 21); issue("R7 bit21 ok", 0, 17'h0);
        // R8 / R3 fetch
        defaults(); ctl_nxe = 1; acc(1,0,1,0); pte = BASE | 64'h7 | (64'h1 << 63);
        issue("R8 R3 nx fetch", 1, 17'h15);
        ctl_nxe = 0; pte = BASE | 64'h3; issue("R8 R3 user fetch sup page no I", 1, 17'h5);
        levels = 3'd2; ctl_nxe = 1; issue("R3 two level nxe no I", 1, 17'h5);
        defaults(); ctl_smep = 1; acc(0,0,1,0); issue("R8 smep sup fetch", 1, 17'h11);
        ctl_smep = 0; issue("R8 sup fetch no smep ok", 0, 17'h0);
        // R9 protection keys
        defaults(); pte = KEY15 | BASE | 64'h7; ctl_pke = 1; ukey_ad = 1; acc(1,0,0,0);
        issue("R9 user AD", 1, 17'h25);
        ukey_ad = 0; ukey_wd = 1; issue("R9 WD read ok", 0, 17'h0);
        acc(1,1,0,0); issue("R9 WD user write", 1, 17'h27);
        acc(0,1,0,0); issue("R9 WD sup write no wp", 0, 17'h0);
        ctl_wp = 1; issue("R9 WD sup write wp", 1, 17'h23);
        ctl_wp = 0; ctl_pke = 0; ukey_ad = 1; acc(1,0,0,0); issue("R9 pke off", 0, 17'h0);
        ctl_pke = 1; acc(1,0,1,0); issue("R9 fetch no key", 0, 17'h0);
        acc(1,0,0,0); is_leaf = 0; issue("R9 non leaf", 0, 17'h0);
        is_leaf = 1; pte = 64'h7000_0000_0000_0000 | BASE | 64'h7; issue("R9 key14", 0, 17'h0);
        defaults(); pte = KEY15 | BASE | 64'h3; ctl_pks = 1; skey_ad = 1;
        issue("R9 sup bank AD", 1, 17'h21);
        // R10 user rights
        defaults(); acc(1,0,0,0); pte = BASE | 64'h3; issue("R10 user sup page", 1, 17'h5);
        acc(1,1,0,0); pte = BASE | 64'h5; issue("R10 user write ro", 1, 17'h7);
        // R11 supervisor rights
        acc(0,1,0,0); issue("R11 sup write ro no wp", 0, 17'h0);
        ctl_wp = 1; issue("R11 sup write ro wp", 1, 17'h3);
        defaults(); ctl_smap = 1; issue("R11 smap ac0", 1, 17'h1);
        ctl_ac = 1; issue("R11 smap ac1 ok", 0, 17'h0);
        acc(0,0,0,1); issue("R11 R12 smap implicit", 1, 17'h10001);
        // R13 priority
        defaults(); acc(1,1,0,0); pte = BASE | 64'h6 | (64'h1 << 50);
        issue("R13 absent over rsvd", 1, 17'h6);
        acc(1,0,0,0); pte = KEY15 | BASE | 64'h7 | (64'h1 << 50); ctl_pke = 1; ukey_ad = 1;
        issue("R13 rsvd over key", 1, 17'hD);
        ctl_pke = 0; pte = BASE | 64'h3 | (64'h1 << 50); issue("R13 rsvd over rights", 1, 17'hD);

        // random pass against the rule model
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r = $urandom;
            levels = 3'd2 + 3'(r[1:0] % 3);
            tbl_level = 3'd1 + 3'(r[3:2]);
            page_order = (r[4] && tbl_level > 1) ? 6'(12 + 9 * (tbl_level - 1)) : 6'd0;
            pa_width = 6'd36 + 6'(r[8:5]);
            vendor_sel = r[9]; gb_pages = r[10]; is_leaf = r[11];
            {acc_user, acc_write, acc_fetch, acc_implicit} = r[15:12];
            {ctl_wp, ctl_ac, ctl_nxe, ctl_smep, ctl_smap, ctl_pke, ctl_pks} = r[22:16];
            {ukey_ad, ukey_wd, skey_ad, skey_wd} = r[26:23];
            pte = {($urandom & 32'hF800_0000), ($urandom & 32'h0000_1187)};
            if (r[27]) pte[62:59] = 4'hF;
            if (r[29:28] == 2'b00) pte[6'($urandom % 64)] = 1'b1;
            issue_model("R13 random vs model");
        end

        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule